// File: doc/BRIEF.md
# Timing Margin Sweep Controller

This block measures the timing margin of a wide data bus against a memory under test by sweeping a delay tap outward from the calibrated centre position. The bus lanes are split into strobe groups. For each group, every data lane is delayed one tap at a time, and the lane's setup margin is the number of the last tap that still passes. Then the group's strobe is delayed in the same way to find the hold margin. The group margin is the smallest lane setup margin in the group plus the strobe hold margin.

The controller drives a tap value, a target selector (group, lane and a data/strobe flag) and a read/write path flag to an external delay line. It raises a step request for each tap and waits for an acknowledge from the test engine. The acknowledge comes with a fail flag for that tap. Once every group is done, the per-group margins can be read back as tap counts and as picoseconds in tenths. A read tap step is 7.3 ps and a write tap step is 14.6 ps.

Top module: `margin_sweep_ctrl`

## Requirements
- R1: After reset the controller is idle. `tap_val` is 0, and `step_req`, `busy` and `done` are low.
- R2: A `start` pulse while idle or done latches `write_mode` and `max_tap` for the run, and `tap_write` shows the latched mode. A `start` pulse during a run is ignored, including any change of mode or limit.
- R3: Each sweep begins at tap 1, and each passing step advances the tap by exactly one. `step_req` stays high with a stable `tap_val` until `step_ack`. After an acknowledge, `step_req` is low for at least one cycle.
- R4: A sweep whose first failure is at tap t records margin t-1, so a failure at tap 1 records 0.
- R5: A sweep that passes at tap `max_tap` ends there and records `max_tap`. The group's `rd_sat` flag is then set. `rd_sat` is clear only when every sweep of the group ended on a failure.
- R6: Groups run in ascending order. Within a group, data lanes 0 to GROUP_LANES-1 are swept in order with `tap_strobe`=0, and then the strobe is swept with `tap_strobe`=1.
- R7: The group margin `rd_margin` equals the minimum lane setup margin of the group plus its strobe hold margin.
- R8: `rd_ps` equals `rd_margin` times 73 after a read run (`write_mode`=0), or times 146 after a write run (`write_mode`=1), in units of 0.1 ps.
- R9: After the last group's strobe sweep, `done` rises, `busy` falls and `tap_val` returns to 0. The results stay readable until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or done |
| write_mode | input | 1 | 1 selects write taps, 0 selects read taps |
| max_tap | input | TAP_W | Largest tap tried per sweep (at least 1) |
| tap_val | output | TAP_W | Tap value to the delay line, 0 when not busy |
| tap_write | output | 1 | Latched path: 1 write, 0 read |
| tap_strobe | output | 1 | 1 while the strobe is being delayed |
| tap_group | output | GW | Strobe group under sweep |
| tap_lane | output | LW | Data lane within the group under setup sweep |
| step_req | output | 1 | Request to test the current tap |
| step_ack | input | 1 | Test engine finished the current tap |
| step_fail | input | 1 | With `step_ack`: the tap failed |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, results valid |
| rd_group | input | GW | Group selected for readout |
| rd_margin | output | TAP_W+1 | Group margin in taps |
| rd_ps | output | TAP_W+9 | Group margin in 0.1 ps |
| rd_sat | output | 1 | Some sweep of the group hit `max_tap` |

## Verification
The engine model in the bench fails each target from a chosen tap onward, and the runs use several kinds of fail tables. One table mixes early and late failures, which shows whether the group result takes the minimum over its lanes rather than the first or last lane. Tables that fail at tap 1 everywhere, or never fail at all, test the two ends of the sweep and the saturation flag. A sweep over every `max_tap` value, with alternating read and write runs and a fail table that shifts with the limit, tests the limit comparison and the picosecond scaling. A `start` pulse in the middle of a run, carrying the other mode and a different limit, must leave both the results and the reported path unchanged.

// File: rtl/margin_sweep_ctrl.sv
module margin_sweep_ctrl #(
  parameter int LANES       = 72,
  parameter int GROUP_LANES = 8,
  parameter int TAP_W       = 6,
  localparam int GROUPS = LANES / GROUP_LANES,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int LW     = (GROUP_LANES > 1) ? $clog2(GROUP_LANES) : 1,
  localparam int PS_W   = TAP_W + 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             write_mode,
  input  logic [TAP_W-1:0] max_tap,
  output logic [TAP_W-1:0] tap_val,
  output logic             tap_write,
  output logic             tap_strobe,
  output logic [GW-1:0]    tap_group,
  output logic [LW-1:0]    tap_lane,
  output logic             step_req,
  input  logic             step_ack,
  input  logic             step_fail,
  output logic             busy,
  output logic             done,
  input  logic [GW-1:0]    rd_group,
  output logic [TAP_W:0]   rd_margin,
  output logic [PS_W-1:0]  rd_ps,
  output logic             rd_sat
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP, S_DONE} st_t;

  st_t              st;
  logic [TAP_W-1:0] tap, maxt, setup_min;
  logic [GW-1:0]    grp;
  logic [LW-1:0]    lane;
  logic             strobe_ph, wr, grp_sat;
  logic [TAP_W:0]   res_margin [GROUPS];
  logic             res_sat    [GROUPS];

  wire              sweep_end = step_fail || (tap >= maxt);
  wire [TAP_W-1:0]  sweep_m   = step_fail ? tap - 1'b1 : maxt;
  wire [TAP_W-1:0]  min_next  = (sweep_m < setup_min) ? sweep_m : setup_min;
  wire              can_start = (st == S_IDLE) || (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tap       <= '0;
      maxt      <= '0;
      setup_min <= '1;
      grp       <= '0;
      lane      <= '0;
      strobe_ph <= 1'b0;
      wr        <= 1'b0;
      grp_sat   <= 1'b0;
      for (int i = 0; i < GROUPS; i++) begin
        res_margin[i] <= '0;
        res_sat[i]    <= 1'b0;
      end
    end else begin
      if (can_start && start) begin
        wr        <= write_mode;
        maxt      <= max_tap;
        tap       <= TAP_W'(1);
        grp       <= '0;
        lane      <= '0;
        strobe_ph <= 1'b0;
        setup_min <= '1;
        grp_sat   <= 1'b0;
        st        <= S_REQ;
      end else if (st == S_GAP) begin
        st <= S_REQ;
      end else if (st == S_REQ && step_ack) begin
        st <= S_GAP;
        if (!sweep_end) begin
          tap <= tap + 1'b1;
        end else begin
          tap <= TAP_W'(1);
          if (!strobe_ph) begin
            setup_min <= min_next;
            grp_sat   <= grp_sat | ~step_fail;
            if (lane == LW'(GROUP_LANES - 1)) strobe_ph <= 1'b1;
            else lane <= lane + 1'b1;
          end else begin
            res_margin[grp] <= {1'b0, setup_min} + {1'b0, sweep_m};
            res_sat[grp]    <= grp_sat | ~step_fail;
            strobe_ph <= 1'b0;
            lane      <= '0;
            setup_min <= '1;
            grp_sat   <= 1'b0;
            if (grp == GW'(GROUPS - 1)) st <= S_DONE;
            else grp <= grp + 1'b1;
          end
        end
      end
    end
  end

  assign busy       = (st == S_REQ) || (st == S_GAP);
  assign done       = (st == S_DONE);
  assign step_req   = (st == S_REQ);
  assign tap_val    = busy ? tap : '0;
  assign tap_write  = wr;
  assign tap_strobe = strobe_ph;
  assign tap_group  = grp;
  assign tap_lane   = lane;

  wire rd_ok = int'(rd_group) < GROUPS;
  assign rd_margin = rd_ok ? res_margin[rd_group] : '0;
  assign rd_sat    = rd_ok ? res_sat[rd_group] : 1'b0;
  assign rd_ps     = PS_W'(rd_margin) * (wr ? PS_W'(146) : PS_W'(73));
endmodule

module margin_sweep_ctrl_chk #(
  parameter int TAP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_req,
  input logic             step_ack,
  input logic             step_fail,
  input logic             busy,
  input logic             done,
  input logic [TAP_W-1:0] tap_val,
  input logic [TAP_W-1:0] maxt
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req && !step_ack |=> step_req && $stable(tap_val));
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req && step_ack |=> !step_req);
  assert_tap_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> tap_val != '0);
  assert_tap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req && step_ack && !step_fail && (tap_val < maxt) |=> tap_val == $past(tap_val) + 1'b1);
  assert_tap_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (maxt == '0) || (tap_val <= maxt));
  assert_idle_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tap_val == '0);
  assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind margin_sweep_ctrl margin_sweep_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_ack(step_ack),
  .step_fail(step_fail), .busy(busy), .done(done), .tap_val(tap_val), .maxt(maxt)
);

// File: tb/tb_margin_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_margin_sweep_ctrl;
  localparam int LANES = 8, GL = 4, TAP_W = 4, GROUPS = 2, GW = 1, LW = 2;

  logic clk = 0, rst_n = 0, start = 0, write_mode = 0;
  logic [TAP_W-1:0] max_tap = '0;
  logic [TAP_W-1:0] tap_val;
  logic tap_write, tap_strobe, step_req, busy, done, rd_sat;
  logic step_ack = 0, step_fail = 0;
  logic [GW-1:0] tap_group;
  logic [LW-1:0] tap_lane;
  logic [GW-1:0] rd_group = '0;
  logic [TAP_W:0] rd_margin;
  logic [TAP_W+8:0] rd_ps;

  int checks = 0, errors = 0;
  int fail_lane [LANES];
  int fail_grp  [GROUPS];
  int exp_mode = 0, exp_max = 1;
  int prev_id = -1, exp_tap = 1, sweep_idx = 0, lat = 0;

  always #10 clk = ~clk;

  margin_sweep_ctrl #(.LANES(LANES), .GROUP_LANES(GL), .TAP_W(TAP_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // test engine model
  initial begin
    forever begin
      @(negedge clk);
      if (step_req) begin
        int id, f, pos;
        id = int'(tap_group) * 16 + int'(tap_strobe) * 8 + int'(tap_lane);
        if (id != prev_id) begin
          pos = sweep_idx % (GL + 1);
          chk(int'(tap_group) == sweep_idx / (GL + 1), "R6 group order", tap_group, sweep_idx / (GL + 1));
          chk(tap_strobe == (pos == GL), "R6 strobe phase", tap_strobe, pos == GL);
          if (pos != GL) chk(int'(tap_lane) == pos, "R6 lane order", tap_lane, pos);
          prev_id = id; exp_tap = 1; sweep_idx++;
        end
        chk(int'(tap_val) == exp_tap, "R3 tap step", tap_val, exp_tap);
        chk(int'(tap_write) == exp_mode, "R2 path flag", tap_write, exp_mode);
        f = tap_strobe ? fail_grp[tap_group] : fail_lane[int'(tap_group) * GL + int'(tap_lane)];
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        step_ack = 1; step_fail = (int'(tap_val) >= f);
        exp_tap++;
        @(negedge clk);
        step_ack = 0; step_fail = 0;
      end
    end
  end

  function automatic int sm(input int f, input int mx);
    return (f > mx) ? mx : f - 1;
  endfunction

  task automatic run(input int mode, input int mx, input bit poke);
    int cyc = 0;
    exp_mode = mode; exp_max = mx; prev_id = -1; sweep_idx = 0;
    @(negedge clk);
    write_mode = mode[0]; max_tap = TAP_W'(mx); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      write_mode = ~mode[0]; max_tap = TAP_W'(1); start = 1;  // R2 ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R9 done", done, 1);
    chk(busy == 1'b0 && tap_val == '0, "R9 idle tap", tap_val, 0);
    chk(sweep_idx == GROUPS * (GL + 1), "R6 sweep count", sweep_idx, GROUPS * (GL + 1));
    for (int g = 0; g < GROUPS; g++) begin
      int mn = 1000, hm, em, sat;
      sat = 0;
      for (int l = 0; l < GL; l++) begin
        if (sm(fail_lane[g * GL + l], mx) < mn) mn = sm(fail_lane[g * GL + l], mx);
        if (fail_lane[g * GL + l] > mx) sat = 1;
      end
      hm = sm(fail_grp[g], mx);
      if (fail_grp[g] > mx) sat = 1;
      em = mn + hm;
      rd_group = GW'(g);
      #1;
      chk(int'(rd_margin) == em, "R7 R4 group margin", rd_margin, em);
      chk(int'(rd_sat) == sat, "R5 saturation flag", rd_sat, sat);
      chk(int'(rd_ps) == em * (mode ? 146 : 73), "R8 ps scaling", rd_ps, em * (mode ? 146 : 73));
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tap_val == '0 && !step_req, "R1 reset tap/req", tap_val, 0);
    chk(!busy && !done, "R1 reset busy/done", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !step_req, "R1 idle after reset", busy, 0);

    // mixed early and late failures, read path
    fail_lane = '{5, 3, 9, 4, 1, 7, 7, 2};
    fail_grp  = '{6, 99};
    run(0, 15, 0);
    rd_group = '0; #1;
    chk(rd_margin == 7, "R7 min plus hold", rd_margin, 7);
    rd_group = 1'b1; #1;
    chk(rd_margin == 15 && rd_sat, "R5 saturated hold", rd_margin, 15);

    // nothing fails, write path
    fail_lane = '{99, 99, 99, 99, 99, 99, 99, 99};
    fail_grp  = '{99, 99};
    run(1, 10, 0);

    // everything fails at tap 1
    fail_lane = '{1, 1, 1, 1, 1, 1, 1, 1};
    fail_grp  = '{1, 1};
    run(1, 6, 0);
    rd_group = '0; #1;
    chk(rd_margin == 0 && !rd_sat, "R4 tap-1 failure", rd_margin, 0);

    // start ignored mid-run
    for (int i = 0; i < LANES; i++) fail_lane[i] = (i * 5 + 3) % 14 + 1;
    for (int g = 0; g < GROUPS; g++) fail_grp[g] = (g * 7 + 2) % 14 + 1;
    run(0, 12, 1);

    // sweep of every limit, alternating path
    for (int m = 1; m < 16; m++) begin
      for (int i = 0; i < LANES; i++) fail_lane[i] = (i * 3 + m) % 17 + 1;
      for (int g = 0; g < GROUPS; g++) fail_grp[g] = (g * 11 + 2 * m) % 17 + 1;
      run(m % 2, m, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule